// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip store for 32-bit formatted trace words. When capture is on, every word presented with its valid strobe is written into a circular RAM at the write pointer. The pointer wraps at the end of the RAM, so older words are overwritten. A trigger strobe arms a post-trigger window whose length is set by a trigger counter. Each word stored after the trigger lowers that counter by one. When it reaches zero, acquisition is marked complete and the RAM stops accepting words. The trace left in the RAM is then the history around the trigger.

Software reaches the block through a plain register port with an address, write data, read data and separate read and write enables. The port covers nine 32-bit registers:

| Address | Register |
|---|---|
| 0 | identification |
| 1 | RAM depth |
| 2 | RAM width |
| 3 | status |
| 4 | data window |
| 5 | read pointer |
| 6 | write pointer |
| 7 | trigger counter |
| 8 | control |

To read the trace back, software points the read pointer at the oldest valid word and reads the data window repeatedly. Each read of the window returns one word and advances the read pointer by one. Where the oldest word sits:

- If the RAM has wrapped, the oldest valid word is at the write pointer.
- If it has not wrapped, the valid words run from entry 0 up to the write pointer minus one.

Top module: `trace_capture_buffer`

## Requirements
- R1: After reset, the following all read zero: both pointers, the trigger counter, the control register, and status bits 0 to 2.
- R2: The identification, depth and width registers are read-only:
  - address 0 returns the identification constant;
  - address 1 returns the RAM entry count;
  - address 2 returns the word width;
  - addresses 9 to 15 read zero;
  - writes to addresses 0 to 4 leave every register's read value unchanged.
- R3: While control bit 0 is 1, each cycle with the valid strobe stores the word at the write pointer and advances the pointer modulo the depth. While control bit 0 is 0, no word is stored and the write pointer holds.
- R4: Status bit 0 (Full) is set when a word is stored at entry depth-1. It stays set until capture is enabled again.
- R5: Status bit 1 (Triggered) is set by the trigger strobe only while control bit 0 is 1. A trigger while disabled is ignored. A second trigger in the same capture changes nothing.
- R6: Post-trigger window:
  - Once Triggered is set, each stored word decrements the trigger counter.
  - A word stored in the same cycle as the trigger does not decrement it.
  - In the first cycle after Triggered is set in which the counter is zero, status bit 2 (Complete) is set, and no word is stored from that cycle on.
- R7: A read of address 4 returns the RAM word at the read pointer, then advances the read pointer modulo the depth. The read pointer can be written at address 5.
- R8: The write pointer (address 6) is writable, keeping the written value modulo the depth. The trigger counter (address 7) is writable and reads back its value.
- R9: Control register (address 8):
  - bit 1 selects demultiplexed port mode and reads back;
  - writing bit 0 as 0 stops capture and leaves the status bits unchanged;
  - writing bit 0 as 1 clears status bits 0 to 2.
- R10: Status bit 3 follows the formatter-empty input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect only on the data window) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| traceValid | input | 1 | Formatted trace word valid |
| traceData | input | 32 | Formatted trace word |
| trigIn | input | 1 | Trigger event strobe |
| fmtEmpty | input | 1 | Formatter-empty flag |

## Verification
The assertions assume the following about the inputs:
- A read strobe and a write strobe are never both raised in one cycle.
- Software writes to the pointer and counter registers arrive in cycles without a trace word.

The stimulus keeps to these rules in both of its parts:
- Register accesses and capture cycles are issued by separate tasks, each occupying exactly one clock.
- The random mix picks either a capture cycle or a single register access per cycle, never both.

The data window is read only after every RAM entry has been written, so every read has a defined value.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 32;

  localparam logic [ADDR_W-1:0] ADDR_ID     = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_DEPTH  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_WIDTH  = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_RDPTR  = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_WRPTR  = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_TRGCNT = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd8;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic storeWord;
    logic decCount;
    logic loadWrPtr;
    logic loadRdPtr;
    logic advRdPtr;
    logic loadCount;
  } dpStrobes_t;
endpackage

// File: rtl/tcb_control.sv
module tcb_control
  import tcb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [1:0]        ctrlBits,
  input  logic              traceValid,
  input  logic              trigIn,
  input  logic              wrPtrAtEnd,
  input  logic              countZero,
  output dpStrobes_t        strobes,
  output logic              captureEn,
  output logic              demuxMode,
  output logic              fullFlag,
  output logic              trigFlag,
  output logic              doneFlag
);
  logic ctrlWr;
  logic clearSticky;
  logic windowClosed;
  logic canStore;

  assign ctrlWr       = regWrEn && (regAddr == ADDR_CTRL);
  assign clearSticky  = ctrlWr && ctrlBits[0];
  // the post-trigger window is exhausted once triggered with a zero count
  assign windowClosed = trigFlag && countZero;
  assign canStore     = captureEn && !doneFlag && !windowClosed;

  always_comb begin
    strobes           = '0;
    strobes.storeWord = traceValid && canStore;
    strobes.decCount  = traceValid && canStore && trigFlag;
    strobes.loadWrPtr = regWrEn && (regAddr == ADDR_WRPTR);
    strobes.loadRdPtr = regWrEn && (regAddr == ADDR_RDPTR);
    strobes.loadCount = regWrEn && (regAddr == ADDR_TRGCNT);
    strobes.advRdPtr  = regRdEn && !regWrEn && (regAddr == ADDR_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captureEn <= 1'b0;
      demuxMode <= 1'b0;
    end else if (ctrlWr) begin
      captureEn <= ctrlBits[0];
      demuxMode <= ctrlBits[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullFlag <= 1'b0;
      trigFlag <= 1'b0;
      doneFlag <= 1'b0;
    end else if (clearSticky) begin
      fullFlag <= 1'b0;
      trigFlag <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (traceValid && canStore && wrPtrAtEnd) fullFlag <= 1'b1;
      if (trigIn && captureEn)                  trigFlag <= 1'b1;
      if (captureEn && windowClosed)            doneFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/tcb_datapath.sv
module tcb_datapath
  import tcb_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 32,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [WORD_W-1:0] traceData,
  input  logic [REG_W-1:0]  regWrData,
  output logic [WORD_W-1:0] rdWord,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic [REG_W-1:0]  trigCount,
  output logic              wrPtrAtEnd,
  output logic              countZero
);
  localparam logic [PTR_W-1:0] LAST_IDX   = PTR_W'(DEPTH - 1);
  localparam bit               DEPTH_POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptrLoadVal;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  // software pointer loads are reduced modulo the depth
  generate
    if (DEPTH_POW2) begin : g_maskLoad
      assign ptrLoadVal = regWrData[PTR_W-1:0];
    end else begin : g_modLoad
      assign ptrLoadVal = PTR_W'(regWrData % REG_W'(DEPTH));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.storeWord) mem[wrPtr] <= traceData;
  end

  assign rdWord     = mem[rdPtr];
  assign wrPtrAtEnd = (wrPtr == LAST_IDX);
  assign countZero  = (trigCount == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      trigCount <= '0;
    end else begin
      if (strobes.loadWrPtr)      wrPtr <= ptrLoadVal;
      else if (strobes.storeWord) wrPtr <= nextPtr(wrPtr);

      if (strobes.loadRdPtr)     rdPtr <= ptrLoadVal;
      else if (strobes.advRdPtr) rdPtr <= nextPtr(rdPtr);

      if (strobes.loadCount)     trigCount <= regWrData;
      else if (strobes.decCount) trigCount <= trigCount - 1'b1;
    end
  end
endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
  import tcb_pkg::*;
#(
  parameter int          DEPTH   = 256,
  parameter int          WORD_W  = 32,
  parameter logic [31:0] ID_CODE = 32'h7B1C_0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  regAddr,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        traceValid,
  input  logic [31:0] traceData,
  input  logic        trigIn,
  input  logic        fmtEmpty
);
  localparam int PTR_W = $clog2(DEPTH);

  dpStrobes_t        strobes;
  logic              captureEn, demuxMode, fullFlag, trigFlag, doneFlag;
  logic              wrPtrAtEnd, countZero;
  logic [WORD_W-1:0] rdWord;
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [REG_W-1:0]  trigCount;

  tcb_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .ctrlBits   (regWrData[1:0]),
    .traceValid (traceValid),
    .trigIn     (trigIn),
    .wrPtrAtEnd (wrPtrAtEnd),
    .countZero  (countZero),
    .strobes    (strobes),
    .captureEn  (captureEn),
    .demuxMode  (demuxMode),
    .fullFlag   (fullFlag),
    .trigFlag   (trigFlag),
    .doneFlag   (doneFlag)
  );

  tcb_datapath #(.DEPTH(DEPTH), .WORD_W(WORD_W), .PTR_W(PTR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .traceData  (traceData[WORD_W-1:0]),
    .regWrData  (regWrData),
    .rdWord     (rdWord),
    .wrPtr      (wrPtr),
    .rdPtr      (rdPtr),
    .trigCount  (trigCount),
    .wrPtrAtEnd (wrPtrAtEnd),
    .countZero  (countZero)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_ID:     regRdData = ID_CODE;
      ADDR_DEPTH:  regRdData = REG_W'(DEPTH);
      ADDR_WIDTH:  regRdData = REG_W'(WORD_W);
      ADDR_STATUS: regRdData[3:0] = {fmtEmpty, doneFlag, trigFlag, fullFlag};
      ADDR_DATA:   regRdData = REG_W'(rdWord);
      ADDR_RDPTR:  regRdData = REG_W'(rdPtr);
      ADDR_WRPTR:  regRdData = REG_W'(wrPtr);
      ADDR_TRGCNT: regRdData = trigCount;
      ADDR_CTRL:   regRdData[1:0] = {demuxMode, captureEn};
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int DEPTH = 256,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       regAddr,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic             wrBit0,
  input logic             trigIn,
  input logic             captureEn,
  input logic             fullFlag,
  input logic             trigFlag,
  input logic             doneFlag,
  input logic [PTR_W-1:0] wrPtr,
  input logic [PTR_W-1:0] rdPtr,
  input logic [31:0]      trigCount
);
  logic reEnable, wrPtrWr, cntWr, dataRead;
  assign reEnable = regWrEn && (regAddr == 4'd8) && wrBit0;
  assign wrPtrWr  = regWrEn && (regAddr == 4'd6);
  assign cntWr    = regWrEn && (regAddr == 4'd7);
  assign dataRead = regRdEn && !regWrEn && (regAddr == 4'd4);

  assert_disabled_no_store_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!captureEn && !wrPtrWr) |=> $stable(wrPtr));

  assert_full_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && !reEnable) |=> fullFlag);

  assert_trigger_needs_enable_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigFlag) |-> ($past(captureEn) && $past(trigIn)));

  assert_done_freezes_wrptr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !wrPtrWr) |=> $stable(wrPtr));

  assert_count_held_before_trigger_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!trigFlag && !cntWr) |=> $stable(trigCount));

  assert_read_advances_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataRead |=> (rdPtr == (($past(rdPtr) == PTR_W'(DEPTH - 1)) ? '0 : $past(rdPtr) + 1'b1)));
endmodule

bind trace_capture_buffer tcb_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regWrEn   (regWrEn),
  .regRdEn   (regRdEn),
  .wrBit0    (regWrData[0]),
  .trigIn    (trigIn),
  .captureEn (captureEn),
  .fullFlag  (fullFlag),
  .trigFlag  (trigFlag),
  .doneFlag  (doneFlag),
  .wrPtr     (wrPtr),
  .rdPtr     (rdPtr),
  .trigCount (trigCount)
);

// File: tb/trace_capture_buffer_tb_top.sv
module trace_capture_buffer_tb_top;
  localparam int          D   = 16;
  localparam logic [31:0] IDV = 32'h5A17_0C3E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        traceValid = 1'b0;
  logic [31:0] traceData = '0;
  logic        trigIn = 1'b0, fmtEmpty = 1'b0;

  trace_capture_buffer #(.DEPTH(D), .WORD_W(32), .ID_CODE(IDV)) dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .traceValid(traceValid),
    .traceData(traceData), .trigIn(trigIn), .fmtEmpty(fmtEmpty)
  );

  int nCmp = 0, nBad = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] mMem [D];
  int          mWr = 0, mRd = 0;
  logic [31:0] mCnt = '0;
  bit          mFull = 0, mTrig = 0, mDone = 0, mEn = 0, mDemux = 0;

  function automatic logic [31:0] expRead(logic [3:0] a);
    case (a)
      4'd0: return IDV;
      4'd1: return 32'(D);
      4'd2: return 32'd32;
      4'd3: return {28'd0, fmtEmpty, mDone, mTrig, mFull};
      4'd4: return mMem[mRd];
      4'd5: return 32'(mRd);
      4'd6: return 32'(mWr);
      4'd7: return mCnt;
      4'd8: return {30'd0, mDemux, mEn};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagOf(logic [3:0] a);
    case (a)
      4'd3:    return "R10";
      4'd4:    return "R7";
      4'd5:    return "R7";
      4'd6:    return "R3";
      4'd7:    return "R8";
      4'd8:    return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelStep(bit v, logic [31:0] d, bit t, bit we, logic [3:0] wa,
                           logic [31:0] wd, bit re, logic [3:0] ra);
    bit canStore, setDone;
    canStore = mEn && !mDone && !(mTrig && mCnt == 0);
    setDone  = mEn && mTrig && mCnt == 0;
    if (v && canStore) begin
      mMem[mWr] = d;
      if (mWr == D - 1) mFull = 1;
      if (mTrig) mCnt = mCnt - 1;
      mWr = (mWr + 1) % D;
    end
    if (t && mEn) mTrig = 1;
    if (setDone) mDone = 1;
    if (re && !we && ra == 4'd4) mRd = (mRd + 1) % D;
    if (we) begin
      case (wa)
        4'd5: mRd = int'(wd % D);
        4'd6: mWr = int'(wd % D);
        4'd7: mCnt = wd;
        4'd8: begin
          mEn = wd[0];
          mDemux = wd[1];
          if (wd[0]) begin mFull = 0; mTrig = 0; mDone = 0; end
        end
        default: ;
      endcase
    end
  endtask

  task automatic cycle(bit v, logic [31:0] d, bit t);
    traceValid = v; traceData = d; trigIn = t;
    modelStep(v, d, t, 0, 4'd0, 32'd0, 0, 4'd0);
    @(posedge clk); @(negedge clk);
    traceValid = 0; trigIn = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    modelStep(0, 32'd0, 0, 1, a, d, 0, 4'd0);
    @(posedge clk); @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdChk(logic [3:0] a, string tag);
    regRdEn = 1; regAddr = a;
    #1;
    check(tag, regRdData, expRead(a));
    modelStep(0, 32'd0, 0, 0, 4'd0, 32'd0, 1, a);
    @(posedge clk); @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    rdChk(4'd3, "R1"); rdChk(4'd5, "R1"); rdChk(4'd6, "R1");
    rdChk(4'd7, "R1"); rdChk(4'd8, "R1");

    // R2 constants, writes to read-only addresses ignored
    rdChk(4'd0, "R2"); rdChk(4'd1, "R2"); rdChk(4'd2, "R2");
    wr(4'd0, '1); wr(4'd1, '1); wr(4'd2, 32'h1234); wr(4'd3, '1); wr(4'd4, '1);
    rdChk(4'd0, "R2"); rdChk(4'd1, "R2"); rdChk(4'd2, "R2");
    rdChk(4'd3, "R2"); rdChk(4'd5, "R2"); rdChk(4'd9, "R2"); rdChk(4'd15, "R2");

    // R3 disabled: nothing stored; R5 trigger ignored while disabled
    for (int i = 0; i < 4; i++) cycle(1, $urandom, 1);
    rdChk(4'd6, "R3"); rdChk(4'd3, "R5");

    // R3/R4 enable, fill past the end of the RAM
    wr(4'd7, 32'd5); wr(4'd8, 32'd1);
    rdChk(4'd8, "R9");
    for (int i = 0; i < 20; i++) cycle(1, $urandom, 0);
    rdChk(4'd6, "R3"); rdChk(4'd3, "R4");

    // R7 read the whole RAM starting at the oldest word
    wr(4'd5, 32'd4);
    for (int i = 0; i < D; i++) rdChk(4'd4, "R7");
    rdChk(4'd5, "R7");

    // R5/R6 trigger, repeated trigger, post-trigger window
    cycle(1, $urandom, 1);
    rdChk(4'd3, "R5"); rdChk(4'd7, "R6");
    cycle(0, 32'd0, 1);
    rdChk(4'd3, "R5");
    for (int i = 0; i < 8; i++) cycle(1, $urandom, 0);
    rdChk(4'd7, "R6"); rdChk(4'd3, "R6"); rdChk(4'd6, "R6");
    for (int i = 0; i < 3; i++) cycle(1, $urandom, 1);
    rdChk(4'd6, "R6");

    // R9 stop keeps sticky bits, demux bit reads back, re-enable clears
    wr(4'd8, 32'd2);
    rdChk(4'd8, "R9");
    for (int i = 0; i < 3; i++) cycle(1, $urandom, 0);
    rdChk(4'd6, "R9"); rdChk(4'd3, "R9");
    wr(4'd8, 32'd3);
    rdChk(4'd3, "R9"); rdChk(4'd8, "R9");

    // R10 formatter-empty mirror
    fmtEmpty = 1; rdChk(4'd3, "R10");
    fmtEmpty = 0; rdChk(4'd3, "R10");

    // R8 writable pointer and counter, modulo on pointer loads
    wr(4'd6, 32'd3); rdChk(4'd6, "R8");
    wr(4'd6, 32'h1234_5677); rdChk(4'd6, "R8");
    wr(4'd7, 32'h0000_DEAD); rdChk(4'd7, "R8");
    wr(4'd5, 32'd37); rdChk(4'd5, "R7");

    // constrained random mix
    for (int i = 0; i < 800; i++) begin
      int r;
      logic [3:0] a;
      r = int'($urandom % 100);
      fmtEmpty = ($urandom % 2) == 1;
      if (r < 60) begin
        cycle(($urandom % 4) != 0, $urandom, ($urandom % 16) == 0);
      end else if (r < 85) begin
        a = 4'($urandom % 10);
        rdChk(a, tagOf(a));
      end else begin
        case ($urandom % 4)
          0: wr(4'd8, (($urandom % 5) == 0) ? 32'd0 : (32'd1 | 32'(($urandom % 2) << 1)));
          1: wr(4'd7, 32'($urandom % 12));
          2: wr(4'd6, $urandom);
          default: wr(4'd5, $urandom);
        endcase
      end
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule